// File: doc/BRIEF.md
# Inter-peer doorbell interrupt register block

This block is a small set of word registers on a 32-bit request bus. A peer that shares a memory region with other peers uses it to ring the others and to take interrupts from them. Software reaches four registers: an interrupt enable, a latched event flag, a read-only identity word and a write-only doorbell. A write to the doorbell sends a one-cycle strobe to an external routing fabric. The strobe carries the target peer and a vector, both taken from the written word.

The static input `msg_mode` chooses how events are handled. With `msg_mode` low (line mode), every doorbell write is forwarded. Incoming events from other peers latch a single flag, and that flag drives the level output `irq` through the enable bit. With `msg_mode` high (vectored mode), the written vector is checked against the parameter `NUM_VEC`. Only vectors in range are forwarded. Incoming events leave the flag untouched.

The identity word returns all ones until `ready` is high. The bus has no wait states. A request is taken on the clock edge where `req_valid` is high. Read data is presented in the next cycle, qualified by `rd_valid`.

Top module: `peer_doorbell_regs`

## Requirements
- R1: Only bits [ADDR_W-1:2] of the address are decoded: word 0 is the enable register, 1 the event flag, 2 the identity, 3 the doorbell. The enable register holds all 32 written bits and reads them back. A read accepted at an edge gives `rd_valid`=1 and its data in the following cycle.
- R2: In line mode, a high `peer_event` at an edge sets the event flag, which then reads as exactly 32'h1.
- R3: `irq` is high exactly when enable bit 0 and the event flag are both 1. Enable bits 31:1 have no effect.
- R4: The identity word reads 32'hFFFFFFFF while `ready` is low, and `self_id` zero-extended while `ready` is high.
- R5: In line mode, a doorbell write gives `db_strobe`=1 for one cycle in the next cycle. That cycle also carries `db_dest`=wdata[31:16] and `db_vector`=wdata[15:0], whatever the low half holds.
- R6: In vectored mode, a doorbell write is forwarded only if wdata[15:0] < NUM_VEC. Otherwise no strobe is produced.
- R7: In vectored mode, `peer_event` never sets the event flag, and `irq` stays low.
- R8: Either a read of word 1 or a write to word 1 with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves it as it was. An event in the same cycle as a clear wins, so the flag stays 1. A read returns the value the flag had before the edge.
- R9: Reading the doorbell gives 0. Writes to the identity word change nothing. Words 4 and above read 0, and writes to them change no register.
- R10: After reset the enable register and the flag are 0, and `irq`, `db_strobe` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_mode | input | 1 | 0 = line mode, 1 = vectored mode; static while out of reset |
| ready | input | 1 | Identity is valid |
| self_id | input | ID_W | Identity of this peer |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the register window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| peer_event | input | 1 | Incoming event from another peer |
| irq | output | 1 | Level interrupt |
| db_strobe | output | 1 | Outgoing doorbell strobe |
| db_dest | output | 16 | Target peer of the strobe |
| db_vector | output | 16 | Vector of the strobe |

## Verification
The assertions assume that `msg_mode` changes only while reset is held, and that at most one request is presented per cycle. On those assumptions, a strobe can always be traced back to a doorbell write, and a raised `irq` implies line mode. The stimulus changes `msg_mode` only between two resets. It drives requests and events on falling edges, one request per cycle. Same-cycle collisions between an event and a clear are created on purpose, because that is the one ordering the block defines.

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs #(
  parameter int ADDR_W  = 10,
  parameter int ID_W    = 16,
  parameter int NUM_VEC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_mode,
  input  logic              ready,
  input  logic [ID_W-1:0]   self_id,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              peer_event,
  output logic              irq,
  output logic              db_strobe,
  output logic [15:0]       db_dest,
  output logic [15:0]       db_vector
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_EN   = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_FLAG = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_ID   = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_DB   = WORD_W'(3);
  localparam logic [16:0] VEC_LIM = 17'(NUM_VEC);

  logic [31:0] en_q;
  logic        stat_q;
  logic [31:0] rd_mux;

  wire [WORD_W-1:0] word = req_addr[ADDR_W-1:2];
  wire wr     = req_valid &  req_write;
  wire rd     = req_valid & ~req_write;
  wire ev_in  = peer_event & ~msg_mode;
  wire vec_ok = ~msg_mode | ({1'b0, req_wdata[15:0]} < VEC_LIM);
  wire ring   = wr & (word == W_DB) & vec_ok;
  wire clr    = (rd & (word == W_FLAG)) | (wr & (word == W_FLAG) & ~req_wdata[0]);
  wire [31:0] id_word = ready ? 32'(self_id) : 32'hFFFF_FFFF;

  always_comb begin
    case (word)
      W_EN:    rd_mux = en_q;
      W_FLAG:  rd_mux = {31'b0, stat_q};
      W_ID:    rd_mux = id_word;
      default: rd_mux = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      stat_q    <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      db_strobe <= 1'b0;
      db_dest   <= '0;
      db_vector <= '0;
    end else begin
      if (wr && word == W_EN) en_q <= req_wdata;
      if (ev_in)              stat_q <= 1'b1;
      else if (clr)           stat_q <= 1'b0;
      rd_valid  <= rd;
      if (rd) rd_data <= rd_mux;
      db_strobe <= ring;
      if (ring) begin
        db_dest   <= req_wdata[31:16];
        db_vector <= req_wdata[15:0];
      end
    end
  end

  assign irq = |(en_q & {31'b0, stat_q});
endmodule

module peer_doorbell_regs_chk #(
  parameter int ADDR_W  = 10,
  parameter int NUM_VEC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_mode,
  input logic              ready,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              peer_event,
  input logic              irq,
  input logic              db_strobe,
  input logic [15:0]       db_vector,
  input logic              stat_q
);
  assert_read_follows_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));
  assert_event_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_event && !msg_mode) |=> stat_q);
  assert_id_unready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(req_addr[ADDR_W-1:2] == 2 && !ready)) |-> rd_data == 32'hFFFF_FFFF);
  assert_strobe_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    db_strobe |-> $past(req_valid && req_write && req_addr[ADDR_W-1:2] == 3));
  assert_vector_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (db_strobe && msg_mode) |-> ({16'b0, db_vector} < NUM_VEC));
  assert_vectored_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |-> !irq);
endmodule

bind peer_doorbell_regs peer_doorbell_regs_chk #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC)) chk_i (.*);

// File: tb/peer_doorbell_regs_tb.sv
module peer_doorbell_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;

  logic clk = 0, rst_n = 0, msg_mode = 0, ready = 0;
  logic [15:0] self_id = 16'h002A;
  logic req_valid = 0, req_write = 0, peer_event = 0;
  logic [9:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, irq, db_strobe;
  logic [31:0] rd_data;
  logic [15:0] db_dest, db_vector;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur = "R10";

  // reference model state
  int  m_en = 0;
  bit  m_flag = 0;
  bit  x_rdv = 0, x_stb = 0;
  int  x_rd = 0, x_dest = 0, x_vec = 0;

  peer_doorbell_regs #(.ADDR_W(10), .ID_W(16), .NUM_VEC(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .ready(ready), .self_id(self_id),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .peer_event(peer_event), .irq(irq),
    .db_strobe(db_strobe), .db_dest(db_dest), .db_vector(db_vector));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_flag = 0; x_rdv = 0; x_stb = 0; x_rd = 0; x_dest = 0; x_vec = 0;
    end else begin
      int a;
      int lo;
      bit nf;
      a  = int'(req_addr) / 4;
      lo = int'(req_wdata) & 'hFFFF;
      nf = m_flag;
      x_rdv = req_valid && !req_write;
      if (x_rdv) begin
        if (a == 0) x_rd = m_en;
        else if (a == 1) x_rd = m_flag ? 1 : 0;
        else if (a == 2) x_rd = ready ? int'(self_id) : -1;
        else x_rd = 0;
        if (a == 1) nf = 0;
      end
      if (req_valid && req_write && a == 1 && (req_wdata % 2 == 0)) nf = 0;
      if (peer_event && !msg_mode) nf = 1;
      x_stb = req_valid && req_write && a == 3 && (!msg_mode || lo < NV);
      if (x_stb) begin
        x_dest = int'(req_wdata >> 16);
        x_vec = lo;
      end
      if (req_valid && req_write && a == 0) m_en = int'(req_wdata);
      m_flag = nf;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit w, input int addr, input logic [31:0] d, input bit ev);
    req_valid = v; req_write = w; req_addr = 10'(addr); req_wdata = d; peer_event = ev;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; peer_event = 0;
    chk(cur, 32'(rd_valid), 32'(x_rdv));
    if (x_rdv) chk(cur, rd_data, x_rd);
    chk(cur, 32'(irq), 32'(m_en % 2 != 0 && m_flag));
    chk(cur, 32'(db_strobe), 32'(x_stb));
    if (x_stb) begin
      chk(cur, 32'(db_dest), x_dest);
      chk(cur, 32'(db_vector), x_vec);
    end
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 0; msg_mode = mode;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset(0);
    cur = "R10";
    cyc(0, 0, 0, 0, 0);
    chk("R10", {29'b0, irq, db_strobe, rd_valid}, 0);
    cur = "R1";
    cyc(1, 0, 0, 0, 0);
    chk("R1", rd_data, 0);
    cyc(1, 1, 0, 32'hA5A5_0001, 0);
    cyc(1, 0, 1, 0, 0);
    cyc(1, 0, 2, 0, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R1", rd_data, 32'hA5A5_0001);
    cur = "R4";
    cyc(1, 0, 8, 0, 0);
    chk("R4", rd_data, 32'hFFFF_FFFF);
    ready = 1;
    cyc(1, 0, 8, 0, 0);
    chk("R4", rd_data, 32'h0000_002A);
    cur = "R2";
    cyc(0, 0, 0, 0, 1);
    cyc(1, 0, 4, 0, 0);
    chk("R2", rd_data, 32'h1);
    cur = "R3";
    cyc(0, 0, 0, 0, 1);
    chk("R3", 32'(irq), 1);
    cyc(1, 1, 0, 32'hFFFF_FFFE, 0);
    chk("R3", 32'(irq), 0);
    cyc(1, 1, 0, 32'h0000_0001, 0);
    chk("R3", 32'(irq), 1);
    cur = "R8";
    cyc(1, 1, 4, 32'h1, 0);
    chk("R8", 32'(irq), 1);
    cyc(1, 1, 4, 32'h0, 0);
    chk("R8", 32'(irq), 0);
    cyc(1, 0, 4, 0, 1);
    chk("R8", 32'(irq), 1);
    cyc(1, 1, 4, 32'h0, 1);
    chk("R8", 32'(irq), 1);
    cyc(1, 0, 4, 0, 0);
    chk("R8", rd_data, 32'h1);
    cyc(1, 0, 4, 0, 0);
    chk("R8", rd_data, 32'h0);
    cur = "R5";
    cyc(1, 1, 12, 32'h0003_BEEF, 0);
    chk("R5", {db_dest, db_vector}, 32'h0003_BEEF);
    cyc(1, 1, 12, 32'h0007_0000, 0);
    chk("R5", 32'(db_strobe), 1);
    cyc(0, 0, 0, 0, 0);
    chk("R5", 32'(db_strobe), 0);
    cur = "R9";
    cyc(1, 0, 12, 0, 0);
    chk("R9", rd_data, 0);
    cyc(1, 1, 8, 32'h1234_5678, 0);
    cyc(1, 0, 8, 0, 0);
    chk("R9", rd_data, 32'h0000_002A);
    cyc(1, 1, 'h100, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 'h100, 0, 0);
    chk("R9", rd_data, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R9", rd_data, 32'h0000_0001);

    do_reset(1);
    cur = "R6";
    cyc(1, 1, 12, 32'h0005_0002, 0);
    chk("R6", 32'(db_strobe), 1);
    cyc(1, 1, 12, 32'h0005_0004, 0);
    chk("R6", 32'(db_strobe), 0);
    cyc(1, 1, 12, 32'h0009_0003, 0);
    chk("R6", {db_dest, db_vector}, 32'h0009_0003);
    cyc(1, 1, 12, 32'h0009_FFFF, 0);
    chk("R6", 32'(db_strobe), 0);
    cur = "R7";
    cyc(1, 1, 0, 32'h1, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R7", 32'(irq), 0);
    cyc(1, 0, 4, 0, 0);
    chk("R7", rd_data, 0);
    finish_run();
  end
endmodule